// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

A synchronous, presettable binary counter of parameterised width (8 bits by default). A two-bit mode input selects clear, count down, parallel load or count up. Every bit of the count register updates on the same rising clock edge. Counting is gated by two active-low enables. Load and clear act whatever the enables are.

An active-low carry output goes low while the count sits at its terminal value for the selected direction and the carry-gating enable is asserted. Wider counters are built by driving the carry-gating enable of each stage from the carry output of the stage below. All stages share the other enable, so an n-bit chain needs no glue logic.

Parameters choose whether clear acts at once (asynchronously) or at the next clock edge, and whether the plain enable also gates the carry output.

Top module: `cascade_counter`

## Requirements
- R1: While rst_ni is low, q_o is 0 at once, without a clock. All bits of q_o change together, on the rising edge of clk_i only (except for the clear of R6).
- R2: In mode_i = 2'b10 (load), q_o takes data_i on the next rising edge, whatever enp_ni and ent_ni are.
- R3: In a counting mode (2'b01 or 2'b11), q_o changes at an edge only if both enp_ni and ent_ni are low at that edge. Otherwise it holds.
- R4: In mode_i = 2'b11 (up), an enabled edge adds one. The maximum value wraps to 0.
- R5: In mode_i = 2'b01 (down), an enabled edge subtracts one. Zero wraps to the maximum value.
- R6: In mode_i = 2'b00 (clear), with ASYNC_CLR=1, q_o goes to 0 at once, without waiting for an edge. With ASYNC_CLR=0, q_o keeps its value until the next rising edge and is 0 after it.
- R7: carry_no is combinational. It is low only when ent_ni is low, the mode is a counting mode and q_o is at the terminal value: all ones in up mode, zero in down mode. In load and clear modes it is high.
- R8: With CARRY_GATE_P=1, carry_no is also forced high while enp_ni is high. With CARRY_GATE_P=0, enp_ni has no effect on carry_no.
- R9: Two stages form a 16-bit counter with wrap and a terminal carry across all 16 bits. In that chain, the upper stage's ent_ni is driven by the lower stage's carry_no, and both stages share enp_ni and mode_i.
- R10: A change on mode_i (other than to the clear of R6), data_i, enp_ni or ent_ni between edges leaves q_o unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 clear, 01 down, 10 load, 11 up |
| enp_ni | input | 1 | Active-low count enable, shared by all stages of a chain |
| ent_ni | input | 1 | Active-low count enable that also gates carry_no |
| data_i | input | WIDTH | Parallel load value |
| q_o | output | WIDTH | Count value |
| carry_no | output | 1 | Active-low terminal-count carry |

## Verification
The bench builds a 16-bit chain from two stages with ASYNC_CLR=1 and CARRY_GATE_P=0. This covers the immediate clear, carries that cross from the low byte to the high byte, and 16-bit terminal detection in both directions. A third, standalone stage is built with ASYNC_CLR=0 and CARRY_GATE_P=1. It covers the clear that waits for an edge and a carry output held high by enp_ni. All three stages see the same stimulus in every cycle, so each mode sequence exercises both parameter variants side by side.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_CLR = 2'b00,
    MODE_DN  = 2'b01,
    MODE_LD  = 2'b10,
    MODE_UP  = 2'b11
  } cnt_mode_e;
endpackage

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  cnt_mode_e          mode_i,
  input  logic               cnt_en_i,
  input  logic [WIDTH-1:0]   q_i,
  input  logic [WIDTH-1:0]   data_i,
  output logic [WIDTH-1:0]   q_next_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (mode_i)
      MODE_CLR: q_next_o = '0;
      MODE_LD:  q_next_o = data_i;
      MODE_UP:  q_next_o = cnt_en_i ? q_i + ONE : q_i;
      MODE_DN:  q_next_o = cnt_en_i ? q_i - ONE : q_i;
      default:  q_next_o = q_i;
    endcase
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  cnt_mode_e        mode_i,
  input  logic [WIDTH-1:0] q_i,
  output logic             term_o
);
  // terminal value depends on direction; non-counting modes never terminate
  always_comb begin
    unique case (mode_i)
      MODE_UP: term_o = &q_i;
      MODE_DN: term_o = ~|q_i;
      default: term_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cnt_state.sv
module cnt_state #(
  parameter int unsigned WIDTH     = 8,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_req_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  if (ASYNC_CLR) begin : g_async_clr
    logic arst_n;
    assign arst_n = rst_ni & ~clr_req_i;
    always_ff @(posedge clk_i or negedge arst_n) begin
      if (!arst_n) q_q <= '0;
      else         q_q <= d_i;
    end
  end else begin : g_sync_clr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_q <= '0;
      else if (clr_req_i) q_q <= '0;
      else                q_q <= d_i;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH        = 8,
  parameter bit          ASYNC_CLR    = 1'b1,
  parameter bit          CARRY_GATE_P = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             enp_ni,
  input  logic             ent_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o,
  output logic             carry_no
);
  cnt_mode_e        mode;
  logic             cnt_en;
  logic             term;
  logic [WIDTH-1:0] q_next;

  assign mode   = cnt_mode_e'(mode_i);
  assign cnt_en = ~enp_ni & ~ent_ni;

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .mode_i   (mode),
    .cnt_en_i (cnt_en),
    .q_i      (q_o),
    .data_i   (data_i),
    .q_next_o (q_next)
  );

  cnt_state #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_req_i (mode == MODE_CLR),
    .d_i       (q_next),
    .q_o       (q_o)
  );

  cnt_term #(.WIDTH(WIDTH)) u_term (
    .mode_i (mode),
    .q_i    (q_o),
    .term_o (term)
  );

  if (CARRY_GATE_P) begin : g_carry_pt
    assign carry_no = ~(term & ~ent_ni & ~enp_ni);
  end else begin : g_carry_t
    assign carry_no = ~(term & ~ent_ni);
  end
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int unsigned WIDTH        = 8,
  parameter bit          ASYNC_CLR    = 1'b1,
  parameter bit          CARRY_GATE_P = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             enp_ni,
  input logic             ent_ni,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] q_o,
  input logic             carry_no
);
  logic aclr_now;
  assign aclr_now = ASYNC_CLR && (mode_i == 2'b00);

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> (q_o == $past(data_i)) || aclr_now);

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[0] && (enp_ni || ent_ni)) |=> (q_o == $past(q_o)) || aclr_now);

  a_r4_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !enp_ni && !ent_ni) |=> (q_o == WIDTH'($past(q_o) + 1'b1)) || aclr_now);

  a_r5_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && !enp_ni && !ent_ni) |=> (q_o == WIDTH'($past(q_o) - 1'b1)) || aclr_now);

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !carry_no && !enp_ni) |=> (q_o == '0));

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> q_o == '0);

  a_r7_ent_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_ni |-> carry_no);

  a_r7_no_count_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[0] |-> carry_no);

  a_r8_enp_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CARRY_GATE_P && enp_ni) |-> carry_no);
endmodule

bind cascade_counter cascade_counter_chk #(
  .WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR), .CARRY_GATE_P(CARRY_GATE_P)
) u_chk (.*);

// File: tb/cascade_counter_bench.sv
`timescale 1ns/1ps
module cascade_counter_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic        enp_n = 1'b1;
  logic        ent_n = 1'b1;
  logic [15:0] din = '0;
  logic [7:0]  q_lo, q_hi, q_s;
  logic        c_lo, c_hi, c_s;
  logic [15:0] m16 = '0;
  logic [7:0]  m8 = '0;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  // lower chain stage
  cascade_counter #(.WIDTH(8), .ASYNC_CLR(1'b1), .CARRY_GATE_P(1'b0)) u_cascade_counter (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .enp_ni(enp_n), .ent_ni(ent_n),
    .data_i(din[7:0]), .q_o(q_lo), .carry_no(c_lo));
  // upper chain stage: ENT from lower carry
  cascade_counter #(.WIDTH(8), .ASYNC_CLR(1'b1), .CARRY_GATE_P(1'b0)) u_cascade_counter_hi (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .enp_ni(enp_n), .ent_ni(c_lo),
    .data_i(din[15:8]), .q_o(q_hi), .carry_no(c_hi));
  // standalone stage, other parameter variant
  cascade_counter #(.WIDTH(8), .ASYNC_CLR(1'b0), .CARRY_GATE_P(1'b1)) u_cascade_counter_sync (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .enp_ni(enp_n), .ent_ni(ent_n),
    .data_i(din[7:0]), .q_o(q_s), .carry_no(c_s));

  function automatic logic [15:0] f_next(input logic [1:0] md, input logic en,
                                         input logic [15:0] q, input logic [15:0] d,
                                         input logic [15:0] mask);
    case (md)
      2'b00:   return '0;
      2'b10:   return d & mask;
      2'b11:   return en ? ((q + 16'd1) & mask) : q;
      default: return en ? ((q - 16'd1) & mask) : q;
    endcase
  endfunction

  function automatic logic f_term(input logic [1:0] md, input logic [15:0] q,
                                  input logic [15:0] mask);
    if (md == 2'b11) return q == mask;
    if (md == 2'b01) return q == 16'd0;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] md, input logic p, input logic t, input logic [15:0] d);
    logic exp_chi, exp_cs;
    @(negedge clk);
    mode = md; enp_n = p; ent_n = t; din = d;
    #1;
    // R10 / R6: before the edge only the async clear can move the chain
    if (md == 2'b00) chk({q_hi, q_lo} == 16'd0, "R6 async clear", {q_hi, q_lo}, 0);
    else chk({q_hi, q_lo} == m16, "R10 chain holds between edges", {q_hi, q_lo}, m16);
    chk(q_s == m8, "R10/R6 sync stage holds between edges", q_s, m8);
    // R7/R9: chain carry over 16 bits, R8: gated carry
    exp_chi = !(!t && f_term(md, m16 & ((md == 2'b00) ? 16'h0 : 16'hFFFF), 16'hFFFF));
    chk(c_hi == exp_chi, "R9 chain carry", c_hi, exp_chi);
    exp_cs = !(!t && !p && f_term(md, {8'h0, m8}, 16'h00FF));
    chk(c_s == exp_cs, "R7/R8 stage carry", c_s, exp_cs);
    m16 = f_next(md, !p && !t, m16, d, 16'hFFFF);
    m8  = f_next(md, !p && !t, {8'h0, m8}, d, 16'h00FF)[7:0];
    @(posedge clk);
    #2;
    chk({q_hi, q_lo} == m16, "R2-R5/R9 chain after edge", {q_hi, q_lo}, m16);
    chk(q_s == m8, "R2-R6 stage after edge", q_s, m8);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #10;
    // R1 reset state
    chk({q_hi, q_lo} == 16'd0, "R1 reset chain", {q_hi, q_lo}, 0);
    chk(q_s == 8'd0, "R1 reset stage", q_s, 0);
    chk(c_hi && c_s, "R7 carry high with ent high", {c_hi, c_s}, 2'b11);
    @(negedge clk);
    rst_ni = 1'b1;
    // R2 load ignores enables
    cyc(2'b10, 1'b1, 1'b1, 16'h00FE);
    // R4 up, carry into the upper byte (R9)
    cyc(2'b11, 1'b0, 1'b0, 16'h0);
    cyc(2'b11, 1'b0, 1'b0, 16'h0);
    // R3 hold with either enable high
    cyc(2'b11, 1'b1, 1'b0, 16'h0);
    cyc(2'b11, 1'b0, 1'b1, 16'h0);
    // R5 down across the byte boundary
    cyc(2'b01, 1'b0, 1'b0, 16'h0);
    cyc(2'b01, 1'b0, 1'b0, 16'h0);
    // R4 wrap at the top, R8 enp gating at terminal
    cyc(2'b10, 1'b0, 1'b0, 16'hFFFF);
    cyc(2'b11, 1'b1, 1'b0, 16'h0);
    cyc(2'b11, 1'b0, 1'b0, 16'h0);
    // R5 wrap at zero
    cyc(2'b01, 1'b0, 1'b0, 16'h0);
    // R6 clear, R10 mode change mid-cycle
    cyc(2'b10, 1'b0, 1'b0, 16'h1234);
    cyc(2'b00, 1'b1, 1'b1, 16'hABCD);
    cyc(2'b10, 1'b0, 1'b0, 16'h5A5A);
    for (int i = 0; i < 2000; i++) begin
      logic [2:0] r = 3'($urandom % 8);
      logic [1:0] md = (r < 3) ? 2'b11 : (r < 6) ? 2'b01 : (r == 6) ? 2'b10 : 2'b00;
      logic [15:0] d = 16'($urandom);
      if ($urandom % 2) d[7:0] = 8'hFF;
      if ($urandom % 4 == 0) d[7:0] = 8'h00;
      cyc(md, ($urandom % 4) == 0, ($urandom % 4) == 0, d);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule